// File: doc/BRIEF.md
# Interleaved Parallel Multiplier

This block multiplies a stream of unsigned operand pairs at one pair per clock while each of its multiplier lanes has several clock cycles to produce its result. It holds `LANES` identical combinational multipliers, each behind its own operand register. A free-running phase counter hands each incoming sample to the next lane in a fixed rotation, so every lane is loaded once every `LANES` cycles. Between loads, each multiplier is a multicycle path of `LANES` cycles.

The same phase counter drives an output multiplexer. It reads a lane's product in the cycle that lane is about to be reloaded, and writes it into a single full-rate output register. Results therefore leave in arrival order and with a fixed latency. Each sample carries a valid bit through its lane, so gaps in the input stream show up as gaps at the output. The phases are clock enables on one clock; no derived clocks are created.

Top module: `imul_interleave`

## Requirements
- R1: While reset is high, and for the first `LANES` cycles after it falls, `outValid` is 0. Reset leaves `outProduct` at 0.
- R2: Every valid result equals the unsigned product `inA * inB` of its sample, `2*DATA_W` bits wide with no truncation. This includes the all-ones, zero and one operands.
- R3: A sample accepted at rising edge E (with `inValid` high and reset low) appears on `outValid`/`outProduct` right after rising edge E+`LANES`.
- R4: Results leave in the same order as the samples arrived. Interleaving across lanes never reorders them.
- R5: An output slot whose matching input cycle had `inValid` low has `outValid` low, so input gaps are kept cycle for cycle.
- R6: In a slot with `outValid` low, `outProduct` holds the last valid product.
- R7: Operand values presented while `inValid` is low have no effect on any later output.
- R8: With `inValid` held high, `outValid` is high in every cycle once the pipeline is full: one result per clock.
- R9: The behaviour above holds for any `LANES` of 1 or more. With `LANES` = 1 the block is a plain two-register multiplier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; all registers use its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operand pair on `inA`/`inB` is a sample this cycle |
| inA | input | DATA_W | First unsigned operand |
| inB | input | DATA_W | Second unsigned operand |
| outValid | output | 1 | `outProduct` carries a new result this cycle |
| outProduct | output | 2*DATA_W | Unsigned product, held between results |

## Verification
Each result is due exactly `LANES` rising edges after the edge that took its sample. The bench logs every driven cycle and samples the outputs at the falling edge. At that point the last edge taken is the one `LANES`+1 positions after the log entry being compared, so for input cycle index i the comparison happens in bench cycle i+`LANES`+1. Four instances with `LANES` of 5, 1, 2 and 4 get the same stimulus, and each is checked against its own offset. The offset covers both the product and the valid flag, and in empty slots it covers the held value.

// File: rtl/imulIlvPkg.sv
package imulIlvPkg;

  // Width of the lane index carried from control to datapath (up to 256 lanes).
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             dataLoad;  // current input is a real sample
    logic [IDX_W-1:0] lane;      // lane loaded this cycle and drained into the output
  } laneCtl_t;

endpackage

// File: rtl/imulIlvControl.sv
module imulIlvControl
  import imulIlvPkg::*;
#(
  parameter int LANES = 5
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  output laneCtl_t ctl
);

  localparam int CNT_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LANES - 1);

  logic [CNT_W-1:0] phaseCnt;

  // Free-running modulo-LANES rotation; one phase per base cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      phaseCnt <= '0;
    end else if (phaseCnt == LAST) begin
      phaseCnt <= '0;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  assign ctl.dataLoad = inValid;
  assign ctl.lane     = IDX_W'(phaseCnt);

endmodule

// File: rtl/imulIlvDatapath.sv
module imulIlvDatapath
  import imulIlvPkg::*;
#(
  parameter int LANES  = 5,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  laneCtl_t              ctl,
  input  logic [DATA_W-1:0]     inA,
  input  logic [DATA_W-1:0]     inB,
  output logic                  outValid,
  output logic [2*DATA_W-1:0]   outProduct
);

  localparam int PW = 2 * DATA_W;

  logic [PW-1:0] laneProd  [LANES];
  logic          laneValid [LANES];

  for (genvar k = 0; k < LANES; k++) begin : gLane
    logic [DATA_W-1:0] opA;
    logic [DATA_W-1:0] opB;
    logic              slotValid;
    logic              hit;

    assign hit = (ctl.lane == IDX_W'(k));

    // Lane registers take the phase as a clock enable; operands only move
    // when a real sample lands, so the multicycle path sees stable inputs.
    always_ff @(posedge clk) begin
      if (rst) begin
        opA       <= '0;
        opB       <= '0;
        slotValid <= 1'b0;
      end else if (hit) begin
        slotValid <= ctl.dataLoad;
        if (ctl.dataLoad) begin
          opA <= inA;
          opB <= inB;
        end
      end
    end

    // Multicycle path: LANES base cycles from lane load to output capture.
    assign laneProd[k]  = PW'(opA) * PW'(opB);
    assign laneValid[k] = slotValid;
  end

  logic [PW-1:0] drainProd;
  logic          drainValid;

  // Drain the lane that is about to be reloaded: it was loaded LANES cycles ago.
  always_comb begin
    drainProd  = '0;
    drainValid = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      if (ctl.lane == IDX_W'(k)) begin
        drainProd  = laneProd[k];
        drainValid = laneValid[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid   <= 1'b0;
      outProduct <= '0;
    end else begin
      outValid <= drainValid;
      if (drainValid) begin
        outProduct <= drainProd;
      end
    end
  end

endmodule

// File: rtl/imul_interleave.sv
module imul_interleave
  import imulIlvPkg::*;
#(
  parameter int LANES  = 5,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [DATA_W-1:0]   inA,
  input  logic [DATA_W-1:0]   inB,
  output logic                outValid,
  output logic [2*DATA_W-1:0] outProduct
);

  laneCtl_t ctl;

  imulIlvControl #(.LANES(LANES)) uCtl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .ctl     (ctl)
  );

  imulIlvDatapath #(.LANES(LANES), .DATA_W(DATA_W)) uDp (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .inA        (inA),
    .inB        (inB),
    .outValid   (outValid),
    .outProduct (outProduct)
  );

endmodule

// File: rtl/imulIlvChecker.sv
module imulIlvChecker #(
  parameter int LANES  = 5,
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                inValid,
  input logic [DATA_W-1:0]   inA,
  input logic [DATA_W-1:0]   inB,
  input logic                outValid,
  input logic [2*DATA_W-1:0] outProduct
);

  localparam int PW = 2 * DATA_W;

  // Shadow delay line of depth LANES+1, stage LANES lines up with the outputs.
  logic          vPipe [LANES+1];
  logic [PW-1:0] pPipe [LANES+1];
  logic [7:0]    sinceRst;
  logic          postRst;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= LANES; i++) begin
        vPipe[i] <= 1'b0;
        pPipe[i] <= '0;
      end
      sinceRst <= '0;
      postRst  <= 1'b0;
    end else begin
      vPipe[0] <= inValid;
      pPipe[0] <= PW'(inA) * PW'(inB);
      for (int i = 1; i <= LANES; i++) begin
        vPipe[i] <= vPipe[i-1];
        pPipe[i] <= pPipe[i-1];
      end
      if (sinceRst != 8'hFF) sinceRst <= sinceRst + 8'd1;
      postRst <= 1'b1;
    end
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    (int'(sinceRst) <= LANES) |-> !outValid); // R1

  AST_VALID_SLOT: assert property (@(posedge clk) disable iff (rst)
    outValid == vPipe[LANES]); // R3

  AST_PRODUCT_VALUE: assert property (@(posedge clk) disable iff (rst)
    outValid |-> outProduct == pPipe[LANES]); // R2

  AST_HOLD_IN_GAP: assert property (@(posedge clk) disable iff (rst)
    (postRst && !outValid) |-> $stable(outProduct)); // R6

endmodule

bind imul_interleave imulIlvChecker #(.LANES(LANES), .DATA_W(DATA_W)) uChk (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .inA        (inA),
  .inB        (inB),
  .outValid   (outValid),
  .outProduct (outProduct)
);

// File: tb/sim_imul_interleave.sv
`timescale 1ns/1ps
module sim_imul_interleave;

  localparam int DW   = 16;
  localparam int PW   = 2 * DW;
  localparam int NCYC = 900;
  localparam int NI   = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          rst;
  logic          inValid;
  logic [DW-1:0] inA, inB;
  logic          ov [NI];
  logic [PW-1:0] op [NI];

  imul_interleave #(.LANES(5), .DATA_W(DW)) u0 (.clk(clk), .rst(rst), .inValid(inValid),
    .inA(inA), .inB(inB), .outValid(ov[0]), .outProduct(op[0]));
  imul_interleave #(.LANES(1), .DATA_W(DW)) u1 (.clk(clk), .rst(rst), .inValid(inValid),
    .inA(inA), .inB(inB), .outValid(ov[1]), .outProduct(op[1]));
  imul_interleave #(.LANES(2), .DATA_W(DW)) u2 (.clk(clk), .rst(rst), .inValid(inValid),
    .inA(inA), .inB(inB), .outValid(ov[2]), .outProduct(op[2]));
  imul_interleave #(.LANES(4), .DATA_W(DW)) u3 (.clk(clk), .rst(rst), .inValid(inValid),
    .inA(inA), .inB(inB), .outValid(ov[3]), .outProduct(op[3]));

  int laneCnt [NI] = '{5, 1, 2, 4};

  logic          histV [NCYC];
  logic [DW-1:0] histA [NCYC];
  logic [DW-1:0] histB [NCYC];
  logic [PW-1:0] heldP [NI];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  function automatic logic [PW-1:0] refMul(logic [DW-1:0] a, logic [DW-1:0] b);
    return PW'(a) * PW'(b);
  endfunction

  function automatic string phaseTag(int idx, bit forValid);
    if (idx < 200)      return forValid ? "R8" : "R4";
    else if (idx < 600) return forValid ? "R5" : "R3";
    else if (idx < 700) return "R2";
    else if (idx < 800) return "R7";
    else                return "R9";
  endfunction

  task automatic checkOne(string tag, int inst, logic [PW-1:0] act, logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s lanes=%0d: actual %0h expected %0h", tag, laneCnt[inst], act, exp);
    end
  endtask

  task automatic checkCycle(int j);
    for (int i = 0; i < NI; i++) begin
      int idx = j - 1 - laneCnt[i];
      logic expV = (idx >= 0) ? histV[idx] : 1'b0;
      if (expV) heldP[i] = refMul(histA[idx], histB[idx]);
      checkOne((idx < 0) ? "R1" : phaseTag(idx, 1'b1), i, PW'(ov[i]), PW'(expV));
      checkOne((idx < 0) ? "R1" : (expV ? phaseTag(idx, 1'b0) : "R6"), i, op[i], heldP[i]);
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < NI; i++) heldP[i] = '0;
    rst = 1'b1; inValid = 1'b1; inA = 16'hFFFF; inB = 16'h1234;
    repeat (3) @(negedge clk);
    // R1: reset state on all variants
    for (int i = 0; i < NI; i++) begin
      checkOne("R1", i, PW'(ov[i]), '0);
      checkOne("R1", i, op[i], '0);
    end
    for (int j = 0; j < NCYC; j++) begin
      checkCycle(j);
      rst = 1'b0;
      if (j < 200) begin                     // R8/R4: continuous stream
        inValid = 1'b1; inA = DW'($urandom); inB = DW'($urandom);
      end else if (j < 600) begin            // R5: random gaps
        inValid = ($urandom % 10) < 6; inA = DW'($urandom); inB = DW'($urandom);
      end else if (j < 700) begin            // R2: operand corners
        inValid = 1'b1;
        case (j % 4)
          0: begin inA = '1; inB = '1; end
          1: begin inA = '0; inB = DW'($urandom); end
          2: begin inA = 16'd1; inB = '1; end
          default: begin inA = '1; inB = 16'd1; end
        endcase
      end else if (j < 800) begin            // R7: garbage with no sample
        inValid = 1'b0; inA = DW'($urandom); inB = DW'($urandom);
      end else begin                         // R9: mixed stream for all lane counts
        inValid = $urandom % 2; inA = DW'($urandom); inB = DW'($urandom);
      end
      histV[j] = inValid; histA[j] = inA; histB[j] = inB;
      @(negedge clk);
    end
    inValid = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (NCYC + 2000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R3 watchdog: run still active, expected end by cycle %0d", NCYC + 2000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule